// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block sits between a set of interrupt-requesting devices and a processor. Each of up to eight devices drives a level-sensitive request line. Each device also has a fixed urgency level between 0 and 7, where 7 is the most urgent. On every clock the arbiter looks at all requests that are asserted and picks the one with the highest level. When several requests share that level, it picks the one with the lowest device index.

The winning level is compared with the priority of the program the processor is currently running. The interrupt line to the processor is raised only when the winning level is strictly above that priority. A request at equal or lower urgency is held off until the processor drops its priority or the request goes away.

The interrupt flag, winning level and winning device index are all registered, so they stay steady for the processor to sample at an instruction boundary. When the processor acknowledges a raised interrupt, the arbiter latches the granted device index and level on a second pair of outputs for vectoring. The device itself is responsible for removing its request.

Top module: `irq_arbiter`

## Requirements
- R1: While rst_n is low, irq_o, win_lvl_o, win_idx_o, gnt_lvl_o and gnt_idx_o are all zero.
- R2: win_lvl_o and win_idx_o show the asserted request with the highest level. When no request is asserted, both are zero.
- R3: When two or more asserted requests share the highest level, win_idx_o is the lowest of their device indices.
- R4: irq_o is 1 only when a request is asserted and the winning level is strictly greater than cur_pl_i. A winning level equal to or below cur_pl_i leaves irq_o at 0.
- R5: Every output is registered. A change on req_i, src_lvl_i, cur_pl_i or ack_i is seen at the outputs after the next rising clock edge and not earlier.
- R6: If ack_i is 1 at a rising edge while irq_o is 1, gnt_idx_o and gnt_lvl_o take the values win_idx_o and win_lvl_o held at that edge. If ack_i is 1 while irq_o is 0, gnt_idx_o and gnt_lvl_o keep their values.
- R7: Requests are level-sensitive. A request that stays asserted after it has been acknowledged keeps winning and keeps irq_o raised until the device deasserts it.
- R8: The level of device i is taken from src_lvl_i bits [i*3+2 : i*3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level-sensitive request, one bit per device |
| src_lvl_i | input | 24 | Static level of each device, 3 bits per device |
| cur_pl_i | input | 3 | Priority of the running program |
| ack_i | input | 1 | Processor acknowledge of a raised interrupt |
| irq_o | output | 1 | Interrupt to the processor |
| win_lvl_o | output | 3 | Level of the current winning request |
| win_idx_o | output | 3 | Device index of the current winning request |
| gnt_lvl_o | output | 3 | Level latched at the last accepted acknowledge |
| gnt_idx_o | output | 3 | Device index latched at the last accepted acknowledge |

## Verification
Every result is due exactly one rising edge after the inputs it depends on. irq_o and the winner outputs reflect the requests, levels and program priority present at the previous edge. The grant outputs reflect an acknowledge seen at the previous edge, together with the winner outputs visible at that edge.

The bench changes inputs only on falling edges. Its behavioural model updates on each rising edge and is compared with the outputs at the following falling edge. One directed check also samples just after an input change, to confirm that nothing has moved before the edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Default geometry: eight devices, eight urgency levels.
    localparam int unsigned DEF_NUM_SRC = 8;
    localparam int unsigned DEF_LVL_W   = 3;

    // Width of an index over n items, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_lvl_select.sv
module irq_lvl_select
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned LVL_W   = DEF_LVL_W,
    localparam int unsigned IDX_W  = idx_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl_i,
    output logic                     any_o,
    output logic [LVL_W-1:0]         lvl_o,
    output logic [IDX_W-1:0]         idx_o
);

    // Per-stage running best. Stage k holds the best among devices 0..k-1.
    logic [NUM_SRC:0]             stg_any;
    logic [NUM_SRC:0][LVL_W-1:0]  stg_lvl;
    logic [NUM_SRC:0][IDX_W-1:0]  stg_idx;

    assign stg_any[0] = 1'b0;
    assign stg_lvl[0] = '0;
    assign stg_idx[0] = '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
        logic [LVL_W-1:0] my_lvl;
        logic             take;
        assign my_lvl = src_lvl_i[g*LVL_W +: LVL_W];
        // Strictly greater: on a tie the earlier (lower index) entry is kept.
        assign take   = req_i[g] && (!stg_any[g] || (my_lvl > stg_lvl[g]));
        assign stg_any[g+1] = stg_any[g] | req_i[g];
        assign stg_lvl[g+1] = take ? my_lvl : stg_lvl[g];
        assign stg_idx[g+1] = take ? IDX_W'(g) : stg_idx[g];
    end

    assign any_o = stg_any[NUM_SRC];
    assign lvl_o = stg_lvl[NUM_SRC];
    assign idx_o = stg_idx[NUM_SRC];

endmodule

// File: rtl/irq_pl_gate.sv
module irq_pl_gate
    import irq_arb_pkg::*;
#(
    parameter int unsigned LVL_W = DEF_LVL_W
) (
    input  logic             any_i,
    input  logic [LVL_W-1:0] win_lvl_i,
    input  logic [LVL_W-1:0] cur_pl_i,
    output logic             fire_o
);

    // Only a strictly more urgent request may preempt the running program.
    always_comb begin
        fire_o = any_i && (win_lvl_i > cur_pl_i);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned LVL_W   = DEF_LVL_W,
    localparam int unsigned IDX_W  = idx_width(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl_i,
    input  logic [LVL_W-1:0]         cur_pl_i,
    input  logic                     ack_i,
    output logic                     irq_o,
    output logic [LVL_W-1:0]         win_lvl_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         gnt_lvl_o,
    output logic [IDX_W-1:0]         gnt_idx_o
);

    typedef struct packed {
        logic             irq;
        logic [LVL_W-1:0] win_lvl;
        logic [IDX_W-1:0] win_idx;
        logic [LVL_W-1:0] gnt_lvl;
        logic [IDX_W-1:0] gnt_idx;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic             sel_any;
    logic [LVL_W-1:0] sel_lvl;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_fire;

    irq_lvl_select #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_select (
        .req_i     (req_i),
        .src_lvl_i (src_lvl_i),
        .any_o     (sel_any),
        .lvl_o     (sel_lvl),
        .idx_o     (sel_idx)
    );

    irq_pl_gate #(
        .LVL_W (LVL_W)
    ) u_gate (
        .any_i     (sel_any),
        .win_lvl_i (sel_lvl),
        .cur_pl_i  (cur_pl_i),
        .fire_o    (sel_fire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq     = sel_fire;
        st_d.win_lvl = sel_any ? sel_lvl : '0;
        st_d.win_idx = sel_any ? sel_idx : '0;
        // The grant records what the processor actually saw when it acknowledged.
        if (ack_i && st_q.irq) begin
            st_d.gnt_lvl = st_q.win_lvl;
            st_d.gnt_idx = st_q.win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign win_lvl_o = st_q.win_lvl;
    assign win_idx_o = st_q.win_idx;
    assign gnt_lvl_o = st_q.gnt_lvl;
    assign gnt_idx_o = st_q.gnt_idx;

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned LVL_W   = 3,
    parameter int unsigned IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       req_i,
    input logic [LVL_W-1:0]         cur_pl_i,
    input logic                     ack_i,
    input logic                     irq_o,
    input logic [LVL_W-1:0]         win_lvl_o,
    input logic [IDX_W-1:0]         win_idx_o,
    input logic [LVL_W-1:0]         gnt_lvl_o,
    input logic [IDX_W-1:0]         gnt_idx_o
);

    // Copy of the requests at the previous edge, indexed by the current winner.
    logic [NUM_SRC-1:0] req_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= req_i;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (!irq_o && win_lvl_o == '0 && gnt_lvl_o == '0));

    assert_idle_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|$past(req_i)) |-> (win_lvl_o == '0 && win_idx_o == '0 && !irq_o));

    assert_winner_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> req_prev[win_idx_o]);

    assert_strictly_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_lvl_o > $past(cur_pl_i)));

    assert_grant_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (gnt_idx_o == $past(win_idx_o) && gnt_lvl_o == $past(win_lvl_o)));

    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> ($stable(gnt_idx_o) && $stable(gnt_lvl_o)));

endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cur_pl_i  (cur_pl_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .win_lvl_o (win_lvl_o),
    .win_idx_o (win_idx_o),
    .gnt_lvl_o (gnt_lvl_o),
    .gnt_idx_o (gnt_idx_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;

    localparam int N  = 8;
    localparam int LW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*LW-1:0] lvls = '0;
    logic [LW-1:0] pl = '0;
    logic          ack = 1'b0;
    logic          irq;
    logic [LW-1:0] wlvl, glvl;
    logic [IW-1:0] widx, gidx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit cmp_en  = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .src_lvl_i(lvls),
        .cur_pl_i(pl), .ack_i(ack), .irq_o(irq), .win_lvl_o(wlvl),
        .win_idx_o(widx), .gnt_lvl_o(glvl), .gnt_idx_o(gidx)
    );

    // Behavioural reference state
    int m_irq, m_lvl, m_idx, m_glvl, m_gidx, m_tie;

    function automatic int lvl_of(int i);
        return int'(lvls[i*LW +: LW]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_irq <= 0; m_lvl <= 0; m_idx <= 0; m_glvl <= 0; m_gidx <= 0; m_tie <= 0;
        end else begin
            int bl, bi, cnt;
            bl = 0; bi = 0; cnt = 0;
            // Scan from most urgent level down; first device hit at that level wins.
            for (int l = (1 << LW) - 1; l >= 0 && cnt == 0; l--) begin
                for (int i = 0; i < N; i++) begin
                    if (req[i] && lvl_of(i) == l) begin
                        if (cnt == 0) begin bl = l; bi = i; end
                        cnt++;
                    end
                end
            end
            if (ack && m_irq != 0) begin
                m_glvl <= m_lvl;
                m_gidx <= m_idx;
            end
            m_irq <= (cnt > 0 && bl > int'(pl)) ? 1 : 0;
            m_lvl <= bl;
            m_idx <= bi;
            m_tie <= (cnt > 1) ? 1 : 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(int'(irq) == m_irq, "R4 irq", int'(irq), m_irq);
            check(int'(wlvl) == m_lvl, "R2 win level", int'(wlvl), m_lvl);
            if (m_tie != 0)
                check(int'(widx) == m_idx, "R3 tie index", int'(widx), m_idx);
            else
                check(int'(widx) == m_idx, "R2 win index", int'(widx), m_idx);
            check(int'(glvl) == m_glvl && int'(gidx) == m_gidx, "R6 grant",
                  int'(gidx) * 8 + int'(glvl), m_gidx * 8 + m_glvl);
        end
    end

    task automatic set_lvl(input int i, input int l);
        lvls[i*LW +: LW] = LW'(l);
    endtask

    task automatic step(input logic [N-1:0] r, input int p, input bit a);
        @(negedge clk);
        #1;
        req = r; pl = LW'(p); ack = a;
    endtask

    initial begin
        // R1: outputs held at zero during reset
        req = 8'hFF; lvls = {N*LW{1'b1}}; pl = '0; ack = 1'b1;
        repeat (3) @(negedge clk);
        check(irq == 1'b0 && wlvl == '0 && widx == '0 && glvl == '0 && gidx == '0,
              "R1 reset", int'(irq) + int'(wlvl) + int'(glvl), 0);
        req = '0; ack = 1'b0; lvls = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R8: distinct levels per device, single requests
        for (int i = 0; i < N; i++) set_lvl(i, (i * 5 + 3) % 8);
        for (int i = 0; i < N; i++) begin
            step(8'(1) << i, 0, 1'b0);
            @(negedge clk);
            check(int'(wlvl) == (i * 5 + 3) % 8 && int'(widx) == i, "R8 level field",
                  int'(wlvl), (i * 5 + 3) % 8);
        end

        // R5: nothing moves before the edge
        step('0, 0, 1'b0);
        step('0, 0, 1'b0);
        @(negedge clk);
        #1;
        req = 8'h01; set_lvl(0, 6);
        #2;
        check(irq == 1'b0 && wlvl == '0, "R5 registered", int'(irq), 0);
        @(negedge clk);
        check(irq == 1'b1 && wlvl == 3'd6, "R5 one edge later", int'(wlvl), 6);

        // R3: ties
        for (int i = 0; i < N; i++) set_lvl(i, 4);
        step(8'b1010_1000, 1, 1'b0);
        step(8'b1111_1110, 1, 1'b0);
        step(8'b1000_0001, 1, 1'b0);

        // R4: equal, below, above
        for (int i = 0; i < N; i++) set_lvl(i, i);
        step(8'b0010_0000, 5, 1'b0);
        step(8'b0010_0000, 6, 1'b0);
        step(8'b0010_0000, 4, 1'b0);
        step(8'b1000_0000, 7, 1'b0);
        step(8'b0000_0001, 0, 1'b0);

        // R6 / R7: ack with irq low is ignored, ack with irq high is captured, request persists
        step(8'b0000_1000, 3, 1'b1);
        step(8'b0000_1000, 3, 1'b1);
        step(8'b0000_1000, 2, 1'b0);
        step(8'b0000_1000, 2, 1'b1);
        step(8'b0000_1000, 2, 1'b0);
        @(negedge clk);
        check(irq == 1'b1 && gidx == 3'd3 && glvl == 3'd3, "R7 request persists",
              int'(gidx), 3);
        step(8'b0100_1000, 2, 1'b1);
        step('0, 2, 1'b0);
        step('0, 2, 1'b1);

        // Mixed traffic
        for (int k = 0; k < 600; k++) begin
            if (k % 50 == 0) lvls = N*LW'($urandom);
            step(N'($urandom & $urandom), int'($urandom % 8), 1'($urandom));
        end
        step('0, 0, 1'b0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule